// File: doc/BRIEF.md
# Serial ADC Conversion Readout Controller

This block is the host-side controller for a 10-bit serial converter. When asked to convert, it pulls the conversion-start line low to open a frame. It then generates exactly sixteen serial-clock periods from the system clock and samples the converter's data line once per period. The 10-bit code it pulls out of the frame is presented with a one-cycle done strobe, together with a wider value. That value is zero-extended when the converter runs unipolar (straight binary) and sign-extended when it runs bipolar (two's complement).

Two kinds of run are supported. In a single-shot run, conversion-start stays low through the last falling clock edge, so the converter releases its shared data line. The line is then held high for one full clock period before the block goes idle. In a continuous run, conversion-start is raised at the 14th falling clock edge. The converter therefore keeps driving, and the next frame's conversion-start falling edge lands on the 16th falling edge of the current frame, with no gap.

The control is one state machine with four states: IDLE, LEAD (conversion-start low, waiting half a period before the first rising edge), SHIFT (sixteen clock periods) and RECOVER (single-shot release and hold-high). Its transitions are:
- IDLE→LEAD on a start request.
- LEAD→SHIFT on the first half-period tick.
- SHIFT→LEAD at the 16th falling edge of a continuous frame.
- SHIFT→RECOVER at the 16th falling edge of a single-shot frame.
- RECOVER→IDLE after three half-period ticks.

Top module: `adc_rdout_ctrl`

## Requirements
- R1: After reset, cnvst_o is 1, sclk_o is 0, busy_o is 0, done_o is 0 and code_o is 0.
- R2: A start_i seen in IDLE drives cnvst_o low and busy_o high one system cycle later. Every serial-clock half period is exactly H system cycles, including the gap from the cnvst_o fall to the first rising edge, where H = max(SCLK_HALF, ceil(SYS_CLK_HZ / (2 × 28.8 MHz))). The serial clock therefore never exceeds 28.8 MHz.
- R3: The serial clock idles low, and each frame has exactly 16 rising and 16 falling edges.
- R4: The data line is sampled at each falling edge. Frame bit k (k = 0..15) is the value sampled at falling edge k+1. code_o is frame bits MSB_OFFSET to MSB_OFFSET+9, most significant first, and every other frame bit has no effect on it.
- R5: done_o is high for exactly one system cycle, one system cycle after the 16th falling edge, and code_o already holds the new result in that cycle.
- R6: Single-shot (continuous_i low at the 14th falling edge): cnvst_o is still low at the 16th falling edge and rises H cycles later. It then stays high for at least 2·H cycles before any new falling edge.
- R7: Continuous (continuous_i high at the 14th falling edge): cnvst_o rises at that falling edge, that is after rising edge 14 and before rising edge 15. The next frame's cnvst_o fall occurs in the same cycle as the 16th falling edge. A frame that sees continuous_i low at its 14th falling edge is the last one.
- R8: A start_i asserted while busy_o is high starts no frame.
- R9: value_o is code_o zero-extended when BIPOLAR = 0 and sign-extended when BIPOLAR = 1. With BIPOLAR = 1, code 10'h200 gives the most negative value and 10'h1FF the most positive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, taken only in IDLE |
| continuous_i | input | 1 | Keep converting back to back (sampled at the 14th falling edge) |
| sdata_i | input | 1 | Serial data from the converter |
| cnvst_o | output | 1 | Conversion-start line, active falling edge |
| sclk_o | output | 1 | Serial clock, idles low |
| busy_o | output | 1 | High whenever the machine is outside IDLE |
| done_o | output | 1 | One-cycle result strobe |
| code_o | output | RES_BITS | Raw converter code |
| value_o | output | VAL_W | Code extended according to BIPOLAR |

## Verification
- cnvst_o and busy_o are due one cycle after start_i. The first rising edge follows the cnvst_o fall by H cycles, and every later clock edge by another H.
- done_o and code_o are due exactly one cycle after the 16th falling edge. In a single-shot frame, the cnvst_o rise is due H cycles after that edge.
- The bench samples on the falling system-clock edge and plays the converter. Each expectation is compared against the cycle number it recorded for the port edge that causes it, so every result is checked in its exact cycle and not merely seen at some point.
- Frame bits outside the result window are filled with random values, so R4 catches a misplaced window.

// File: rtl/adc_rdout_pkg.sv
package adc_rdout_pkg;

    localparam int unsigned SCLK_MAX_HZ = 28_800_000;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_RECOVER
    } rd_state_e;

    // smallest half period (in system cycles) keeping the serial clock legal
    function automatic int unsigned min_half(input int unsigned sys_hz);
        return (sys_hz + 2 * SCLK_MAX_HZ - 1) / (2 * SCLK_MAX_HZ);
    endfunction

endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
    parameter int unsigned HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int unsigned CW = $clog2(HALF + 1);

    logic [CW-1:0] cnt;
    logic          at_end;

    assign at_end = (cnt == CW'(HALF - 1));
    assign tick_o = en_i && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en_i || at_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/adc_frame_shift.sv
module adc_frame_shift #(
    parameter int unsigned FRAME_BITS = 16,
    parameter int unsigned RES_BITS   = 10,
    parameter int unsigned MSB_OFFSET = 4,
    parameter int unsigned VAL_W      = 16,
    parameter bit          BIPOLAR    = 1'b1,
    localparam int unsigned IW        = $clog2(FRAME_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_i,
    input  logic [IW-1:0]       idx_i,
    input  logic                bit_i,
    input  logic                load_i,
    output logic [RES_BITS-1:0] code_o,
    output logic [VAL_W-1:0]    value_o
);
    localparam int unsigned EXT_W = VAL_W - RES_BITS;

    logic [RES_BITS-1:0] sh;
    logic [RES_BITS-1:0] code_q;
    logic                in_window;

    assign in_window = (int'(idx_i) >= int'(MSB_OFFSET)) &&
                       (int'(idx_i) <  int'(MSB_OFFSET + RES_BITS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh     <= '0;
            code_q <= '0;
        end else begin
            if (cap_i && in_window) begin
                sh <= {sh[RES_BITS-2:0], bit_i};
            end
            if (load_i) begin
                code_q <= sh;
            end
        end
    end

    assign code_o = code_q;

    generate
        if (BIPOLAR) begin : g_twos
            assign value_o = {{EXT_W{code_q[RES_BITS-1]}}, code_q};
        end else begin : g_binary
            assign value_o = {{EXT_W{1'b0}}, code_q};
        end
    endgenerate

endmodule

// File: rtl/adc_rdout_ctrl.sv
module adc_rdout_ctrl
    import adc_rdout_pkg::*;
#(
    parameter int unsigned SYS_CLK_HZ = 50_000_000,
    parameter int unsigned SCLK_HALF  = 2,
    parameter int unsigned FRAME_BITS = 16,
    parameter int unsigned RES_BITS   = 10,
    parameter int unsigned MSB_OFFSET = 4,
    parameter int unsigned VAL_W      = 16,
    parameter bit          BIPOLAR    = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                continuous_i,
    input  logic                sdata_i,
    output logic                cnvst_o,
    output logic                sclk_o,
    output logic                busy_o,
    output logic                done_o,
    output logic [RES_BITS-1:0] code_o,
    output logic [VAL_W-1:0]    value_o
);
    localparam int unsigned MIN_HALF = min_half(SYS_CLK_HZ);
    localparam int unsigned HALF_EFF = (SCLK_HALF < MIN_HALF) ? MIN_HALF : SCLK_HALF;
    localparam int unsigned CNT_W    = $clog2(FRAME_BITS + 1);

    rd_state_e        state, nxt;
    logic             tick;
    logic [CNT_W-1:0] fall_cnt;
    logic [1:0]       rec_cnt;
    logic             cnvst_q, sclk_q, cont_q;
    logic             done_pend, done_q;
    logic             fall_ev, last_fall, mark_fall;

    adc_sclk_div #(.HALF(HALF_EFF)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (state != ST_IDLE),
        .tick_o (tick)
    );

    assign fall_ev   = tick && (state == ST_SHIFT) && sclk_q;
    assign last_fall = fall_ev && (fall_cnt == CNT_W'(FRAME_BITS - 1));
    assign mark_fall = fall_ev && (fall_cnt == CNT_W'(FRAME_BITS - 3));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start_i) nxt = ST_LEAD;
            ST_LEAD:    if (tick) nxt = ST_SHIFT;
            ST_SHIFT:   if (last_fall) nxt = cont_q ? ST_LEAD : ST_RECOVER;
            ST_RECOVER: if (tick && rec_cnt == 2'd2) nxt = ST_IDLE;
        endcase
    end

    // outputs and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnvst_q   <= 1'b1;
            sclk_q    <= 1'b0;
            fall_cnt  <= '0;
            rec_cnt   <= '0;
            cont_q    <= 1'b0;
            done_pend <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_pend <= last_fall;
            done_q    <= done_pend;
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        cnvst_q  <= 1'b0;
                        fall_cnt <= '0;
                        rec_cnt  <= '0;
                    end
                end
                ST_LEAD: begin
                    if (tick) sclk_q <= 1'b1;
                end
                ST_SHIFT: begin
                    if (tick) sclk_q <= !sclk_q;
                    if (fall_ev) fall_cnt <= fall_cnt + 1'b1;
                    if (mark_fall) begin
                        cont_q <= continuous_i;
                        if (continuous_i) cnvst_q <= 1'b1;
                    end
                    if (last_fall && cont_q) begin
                        cnvst_q  <= 1'b0;
                        fall_cnt <= '0;
                    end
                end
                ST_RECOVER: begin
                    if (tick) begin
                        rec_cnt <= rec_cnt + 1'b1;
                        cnvst_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    adc_frame_shift #(
        .FRAME_BITS (FRAME_BITS),
        .RES_BITS   (RES_BITS),
        .MSB_OFFSET (MSB_OFFSET),
        .VAL_W      (VAL_W),
        .BIPOLAR    (BIPOLAR)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_i   (fall_ev),
        .idx_i   (fall_cnt),
        .bit_i   (sdata_i),
        .load_i  (done_pend),
        .code_o  (code_o),
        .value_o (value_o)
    );

    assign cnvst_o = cnvst_q;
    assign sclk_o  = sclk_q;
    assign busy_o  = (state != ST_IDLE);
    assign done_o  = done_q;

    // R1
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (cnvst_q && !sclk_q));

    // R2
    sclk_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_q != $past(sclk_q)) |-> $past(tick));

    // R3
    fall_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_cnt <= CNT_W'(FRAME_BITS));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R5
    done_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!$past(sclk_q) && $past(sclk_q, 2)));

    // R7
    early_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cnvst_q) && $past(state) == ST_SHIFT) |-> (fall_cnt == CNT_W'(FRAME_BITS - 2)));

endmodule

// File: tb/tb_adc_rdout_ctrl.sv
module tb_adc_rdout_ctrl;
    localparam int HALF_P = 2;
    localparam int OFF    = 4;
    localparam int FB     = 16;
    localparam int RB     = 10;
    localparam int VW     = 16;
    localparam int SYSF   = 50_000_000;
    localparam int MAXF   = 28_800_000;
    localparam int MINH   = (SYSF + 2 * MAXF - 1) / (2 * MAXF);
    localparam int HALF_E = (HALF_P > MINH) ? HALF_P : MINH;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic continuous_i = 1'b0;
    logic sdata = 1'b0;
    logic cnvst_o, sclk_o, busy_o, done_o;
    logic [RB-1:0] code_o;
    logic [VW-1:0] value_o;
    logic cnvst_u, sclk_u, busy_u, done_u;
    logic [RB-1:0] code_u;
    logic [VW-1:0] value_u;

    always #10 clk = ~clk;

    adc_rdout_ctrl #(.SYS_CLK_HZ(SYSF), .SCLK_HALF(HALF_P), .MSB_OFFSET(OFF), .BIPOLAR(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .continuous_i(continuous_i), .sdata_i(sdata),
        .cnvst_o(cnvst_o), .sclk_o(sclk_o), .busy_o(busy_o), .done_o(done_o),
        .code_o(code_o), .value_o(value_o));

    adc_rdout_ctrl #(.SYS_CLK_HZ(SYSF), .SCLK_HALF(HALF_P), .MSB_OFFSET(OFF), .BIPOLAR(1'b0)) dut_uni (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .continuous_i(continuous_i), .sdata_i(sdata),
        .cnvst_o(cnvst_u), .sclk_o(sclk_u), .busy_o(busy_u), .done_o(done_u),
        .code_o(code_u), .value_o(value_u));

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [RB-1:0] pick(input int n);
        case (n)
            0: return 10'h200;
            1: return 10'h1FF;
            2: return 10'h000;
            3: return 10'h3FF;
            default: return RB'($urandom);
        endcase
    endfunction

    function automatic logic [VW-1:0] sext(input logic [RB-1:0] c);
        return {{(VW-RB){c[RB-1]}}, c};
    endfunction

    function automatic logic [VW-1:0] zext(input logic [RB-1:0] c);
        return {{(VW-RB){1'b0}}, c};
    endfunction

    // converter model and protocol monitor
    int cyc = 0, last_tog = 0, fall16_cyc = -100, hi_cyc = 0;
    int rise_cnt = 0, fall_cnt = 0, rose_mid_rise = 0;
    int n_frames = 0, n_done = 0;
    bit rose_mid = 0, cont_at14 = 0, prev_cont = 0;
    logic p_sclk = 1'b0, p_cnvst = 1'b1, p_done = 1'b0;
    logic [FB-1:0] frame_bits = '0;
    logic [RB-1:0] exp_code [0:63];

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (sclk_o && !p_sclk) begin
                rise_cnt++;
                check(cyc - last_tog == HALF_E, "R2", "rise spacing", cyc - last_tog, HALF_E);
                last_tog = cyc;
                if (rise_cnt <= FB) sdata = frame_bits[FB - rise_cnt];
            end
            if (!sclk_o && p_sclk) begin
                fall_cnt++;
                check(cyc - last_tog == HALF_E, "R2", "fall spacing", cyc - last_tog, HALF_E);
                last_tog = cyc;
                if (fall_cnt == FB - 2) cont_at14 = continuous_i;
                if (fall_cnt == FB) begin
                    fall16_cyc = cyc;
                    check(rise_cnt == FB, "R3", "rises per frame", rise_cnt, FB);
                    if (cont_at14)
                        check(rose_mid && rose_mid_rise == FB - 2, "R7", "early cnvst rise at rise count", rose_mid_rise, FB - 2);
                    else
                        check(cnvst_o == 1'b0 && !rose_mid, "R6", "cnvst low at last fall", int'(cnvst_o), 0);
                end
                if (fall_cnt > FB) check(1'b0, "R3", "falls per frame", fall_cnt, FB);
            end
            if (cnvst_o && !p_cnvst) begin
                if (fall_cnt == FB) begin
                    check(cyc - fall16_cyc == HALF_E, "R6", "release delay", cyc - fall16_cyc, HALF_E);
                    sdata = 1'bz;
                end else begin
                    rose_mid = 1'b1;
                    rose_mid_rise = rise_cnt;
                end
                hi_cyc = cyc;
            end
            if (!cnvst_o && p_cnvst) begin
                if (n_frames > 0) begin
                    if (cont_at14)
                        check(cyc == fall16_cyc, "R7", "back-to-back start cycle", cyc, fall16_cyc);
                    else
                        check(cyc - hi_cyc >= 2 * HALF_E, "R6", "cnvst high time", cyc - hi_cyc, 2 * HALF_E);
                end
                prev_cont = cont_at14;
                cont_at14 = 1'b0;
                exp_code[n_frames % 64] = pick(n_frames);
                frame_bits = FB'($urandom);
                frame_bits[FB-1-OFF -: RB] = exp_code[n_frames % 64];
                n_frames++;
                rise_cnt = 0;
                fall_cnt = 0;
                rose_mid = 1'b0;
                last_tog = cyc;
                sdata = 1'b0;
            end
            if (p_done) check(!done_o, "R5", "done width", int'(done_o), 0);
            if (done_o) begin
                check(cyc == fall16_cyc + 1, "R5", "done cycle", cyc, fall16_cyc + 1);
                check(code_o == exp_code[n_done % 64], "R4", "code", int'(code_o), int'(exp_code[n_done % 64]));
                check(value_o == sext(exp_code[n_done % 64]), "R9", "bipolar value", int'(value_o), int'(sext(exp_code[n_done % 64])));
                check(value_u == zext(exp_code[n_done % 64]), "R9", "unipolar value", int'(value_u), int'(zext(exp_code[n_done % 64])));
                n_done++;
            end
            p_sclk = sclk_o;
            p_cnvst = cnvst_o;
            p_done = done_o;
        end
    end

    task automatic do_start();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(cnvst_o == 1'b0 && busy_o == 1'b1, "R2", "cnvst/busy after start", int'({cnvst_o, busy_o}), 1);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy_o) @(negedge clk);
    endtask

    task automatic wait_done(input int n);
        while (n_done < n) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cnvst_o == 1'b1 && sclk_o == 1'b0, "R1", "reset lines", int'({cnvst_o, sclk_o}), 2);
        check(busy_o == 1'b0 && done_o == 1'b0, "R1", "reset busy/done", int'({busy_o, done_o}), 0);
        check(code_o == '0, "R1", "reset code", int'(code_o), 0);

        // single-shot frames with directed codes first, then random ones
        for (int i = 0; i < 10; i++) begin
            do_start();
            if (i == 5) begin
                repeat (20) @(negedge clk);
                start_i = 1'b1;   // R8: busy, must be ignored
                @(negedge clk);
                start_i = 1'b0;
            end
            if (i == 6) begin
                wait_done(i + 1);
                start_i = 1'b1;   // R8: in release phase, must be ignored
                @(negedge clk);
                start_i = 1'b0;
            end
            wait_done(i + 1);
            wait_idle();
        end
        repeat (10) @(negedge clk);
        check(n_frames == 10, "R8", "frames after ignored starts", n_frames, 10);

        // continuous run of five frames
        continuous_i = 1'b1;
        do_start();
        wait_done(14);
        continuous_i = 1'b0;
        wait_idle();
        repeat (10) @(negedge clk);
        check(n_frames == 15, "R7", "frames in continuous run", n_frames, 15);
        check(n_done == 15, "R7", "results in continuous run", n_done, 15);

        // single shot after continuous
        do_start();
        wait_done(16);
        wait_idle();
        check(cnvst_o == 1'b1 && sclk_o == 1'b0, "R3", "lines idle after frame", int'({cnvst_o, sclk_o}), 2);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule